// File: doc/BRIEF.md
# Multi-Phase Serial Audio Transmitter

This block turns parallel audio words into a serial bit stream. A frame begins when the frame sync becomes active. The block then shifts the words out most significant bit first, one bit for each bit-clock strobe. The strobe is a single-cycle pulse in the system clock domain that marks the bit-clock edge on which transmit data changes. In normal polarity that is the falling edge.

A frame has either one phase or two. In a single-phase frame, one programmable word count covers the whole frame, up to 16 words, for example one word per channel. In a dual-phase frame, a first and a second phase follow each other, and each has its own word count. Stereo I2S is sent as a dual-phase frame with one word in each phase. Each word count is programmed as the count minus one.

The first data bit comes either on the strobe that sees the frame sync or one strobe later. I2S and DSP_A use the one-bit delay; DSP_B uses none. The active level of the frame sync can be inverted, as the DSP formats require. Words arrive over a valid/ready handshake. If no word is offered when one is due, the block sends zeros and raises a sticky underrun flag.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset, tx_oe, tx_sd, s_ready and underrun are all 0.
- R2: Each word is WORD_W (16) bits, sent most significant bit first. tx_sd and tx_oe change only on the clock edge that samples bit_tick high.
- R3: The effective frame sync is fsync XOR cfg_fs_invert, with 1 meaning active. A frame starts only on a strobe where the effective sync is 1 and was 0 at the previous strobe.
- R4: With cfg_delay_one=0, the first data bit is driven by the start strobe. With cfg_delay_one=1, it is driven by the next strobe.
- R5: With cfg_dual_phase=0, a frame carries cfg_ph1_words_m1+1 words, up to 16.
- R6: With cfg_dual_phase=1, a frame carries cfg_ph1_words_m1+1 words and then cfg_ph2_words_m1+1 words, as one continuous stream.
- R7: tx_oe is 1 exactly while a data bit is on the line. Whenever tx_oe is 0, tx_sd is 0.
- R8: s_ready is high only in a strobe cycle that loads a word, once per word of the frame. The word on s_data is taken if s_valid is high in that cycle.
- R9: If s_valid is low when s_ready is high, that word slot is sent as all zeros and underrun becomes 1. It stays 1 until reset, and it is 0 while every word is supplied.
- R10: A new frame-sync edge during a frame in progress (before its last bit) is ignored.
- R11: With cfg_delay_one=0, a frame-sync edge on the strobe after a frame's last bit starts the next frame with no gap in tx_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe at each transmit bit-clock edge |
| fsync | input | 1 | Frame sync, sampled at strobes |
| cfg_dual_phase | input | 1 | 1 selects two phases per frame |
| cfg_ph1_words_m1 | input | 4 | First-phase word count minus one |
| cfg_ph2_words_m1 | input | 4 | Second-phase word count minus one |
| cfg_delay_one | input | 1 | 1 delays the first bit by one strobe |
| cfg_fs_invert | input | 1 | 1 makes fsync active low |
| s_valid | input | 1 | A word is offered on s_data |
| s_data | input | 16 | Parallel audio word |
| s_ready | output | 1 | A word is taken in this cycle |
| tx_sd | output | 1 | Serial data line |
| tx_oe | output | 1 | Output enable of the data line |
| underrun | output | 1 | Sticky: a word was due with none offered |

## Verification
Every line result is registered on the clock edge that samples the strobe. So a bit produced by strobe t is visible from the next edge, and it is captured at the following falling clock edge as result t. With a start strobe at index S and delay d, bit k of the frame must appear at index S+d+k. s_ready is combinational within the strobe cycle, so the bench reads it one nanosecond after raising the strobe. The underrun flag is read once a frame has finished. Each scenario builds its expected stream from its word list and word-slot order, and compares every captured strobe result against it, gaps included.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_SHIFT
  } seq_state_t;

  // A phase that ends on its last word closes the frame when it is the second
  // phase, or when the frame only has one phase.
  function automatic logic phase_closes_frame(input logic in_ph2, input logic dual);
    return in_ph2 || !dual;
  endfunction

  // The frame sync as seen by the sequencer: 1 means active.
  function automatic logic sync_active(input logic pin, input logic invert);
    return pin ^ invert;
  endfunction

endpackage

// File: rtl/sat_fs_detect.sv
module sat_fs_detect
  import sat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic fsync,
  input  logic cfg_fs_invert,
  output logic frame_start
);

  logic fs_act;
  logic fs_prev;

  assign fs_act      = sync_active(fsync, cfg_fs_invert);
  assign frame_start = bit_tick && fs_act && !fs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fs_prev <= 1'b0;
    else if (bit_tick) fs_prev <= fs_act;
  end

endmodule

// File: rtl/sat_sequencer.sv
module sat_sequencer
  import sat_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 16,
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int CNT_W    = $clog2(MAX_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             frame_start,
  input  logic             cfg_dual_phase,
  input  logic [CNT_W-1:0] cfg_ph1_words_m1,
  input  logic [CNT_W-1:0] cfg_ph2_words_m1,
  input  logic             cfg_delay_one,
  output logic             word_load,
  output logic             bit_shift,
  output logic             active
);

  seq_state_t       st;
  logic [BIT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] word_cnt;
  logic             in_ph2;

  logic last_bit, ph_last_word, frame_end, start_ok;

  always_comb begin
    last_bit     = (bit_cnt == BIT_W'(WORD_W - 1));
    ph_last_word = (word_cnt == (in_ph2 ? cfg_ph2_words_m1 : cfg_ph1_words_m1));
    frame_end    = (st == ST_SHIFT) && last_bit && ph_last_word &&
                   phase_closes_frame(in_ph2, cfg_dual_phase);
    start_ok     = frame_start && ((st == ST_IDLE) || frame_end);
    word_load    = bit_tick && ((start_ok && !cfg_delay_one) ||
                                (st == ST_DELAY) ||
                                ((st == ST_SHIFT) && last_bit && !frame_end));
    bit_shift    = bit_tick && (st == ST_SHIFT) && !last_bit;
  end

  assign active = (st == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      word_cnt <= '0;
      in_ph2   <= 1'b0;
    end else if (bit_tick) begin
      case (st)
        ST_IDLE: begin
          if (start_ok) begin
            st       <= cfg_delay_one ? ST_DELAY : ST_SHIFT;
            bit_cnt  <= '0;
            word_cnt <= '0;
            in_ph2   <= 1'b0;
          end
        end
        ST_DELAY: begin
          st       <= ST_SHIFT;
          bit_cnt  <= '0;
          word_cnt <= '0;
          in_ph2   <= 1'b0;
        end
        ST_SHIFT: begin
          if (!last_bit) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (frame_end) begin
            st       <= start_ok ? (cfg_delay_one ? ST_DELAY : ST_SHIFT) : ST_IDLE;
            bit_cnt  <= '0;
            word_cnt <= '0;
            in_ph2   <= 1'b0;
          end else if (!ph_last_word) begin
            word_cnt <= word_cnt + 1'b1;
            bit_cnt  <= '0;
          end else begin
            in_ph2   <= 1'b1;
            word_cnt <= '0;
            bit_cnt  <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_DELAY_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DELAY && bit_tick) |=> (st == ST_SHIFT)) else $error("delay state overstayed"); // R4

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_load && bit_shift)) else $error("load and shift together"); // R2

endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              word_load,
  input  logic              bit_shift,
  input  logic              active,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              tx_sd,
  output logic              underrun
);

  logic [WORD_W-1:0] sreg;
  logic              starved;

  assign s_ready = word_load;
  assign starved = word_load && !s_valid;
  assign tx_sd   = active && sreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (word_load) begin
      sreg <= s_valid ? s_data : '0;
    end else if (bit_shift) begin
      sreg <= {sreg[WORD_W-2:0], 1'b0};
    end else if (bit_tick) begin
      sreg <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       underrun <= 1'b0;
    else if (starved) underrun <= 1'b1;
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(underrun) |-> underrun) else $error("underrun cleared"); // R9

  AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(s_ready && !s_valid)) else $error("underrun without starvation"); // R9

  AST_READY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bit_tick) else $error("ready outside strobe"); // R8

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
  import sat_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAX_WORDS = 16,
  localparam int CNT_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              fsync,
  input  logic              cfg_dual_phase,
  input  logic [CNT_W-1:0]  cfg_ph1_words_m1,
  input  logic [CNT_W-1:0]  cfg_ph2_words_m1,
  input  logic              cfg_delay_one,
  input  logic              cfg_fs_invert,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              tx_sd,
  output logic              tx_oe,
  output logic              underrun
);

  logic frame_start;
  logic word_load;
  logic bit_shift;
  logic active;

  sat_fs_detect i_fs_detect (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .fsync         (fsync),
    .cfg_fs_invert (cfg_fs_invert),
    .frame_start   (frame_start)
  );

  sat_sequencer #(
    .WORD_W    (WORD_W),
    .MAX_WORDS (MAX_WORDS)
  ) i_sequencer (
    .clk              (clk),
    .rst_n            (rst_n),
    .bit_tick         (bit_tick),
    .frame_start      (frame_start),
    .cfg_dual_phase   (cfg_dual_phase),
    .cfg_ph1_words_m1 (cfg_ph1_words_m1),
    .cfg_ph2_words_m1 (cfg_ph2_words_m1),
    .cfg_delay_one    (cfg_delay_one),
    .word_load        (word_load),
    .bit_shift        (bit_shift),
    .active           (active)
  );

  sat_shifter #(
    .WORD_W (WORD_W)
  ) i_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .word_load (word_load),
    .bit_shift (bit_shift),
    .active    (active),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .tx_sd     (tx_sd),
    .underrun  (underrun)
  );

  assign tx_oe = active;

  AST_OE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(tx_oe)) else $error("oe moved without strobe"); // R2

  AST_SD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(tx_sd)) else $error("sd moved without strobe"); // R2

  AST_LOAD_STARTS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |=> tx_oe) else $error("loaded word not driven"); // R7

endmodule

// File: tb/test_serial_audio_tx.sv
module test_serial_audio_tx;
  localparam int WW   = 16;
  localparam int NT   = 320;
  localparam int NSLT = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          bit_tick = 1'b0;
  logic          fsync = 1'b0;
  logic          cfg_dual_phase = 1'b0;
  logic [3:0]    cfg_ph1_words_m1 = '0;
  logic [3:0]    cfg_ph2_words_m1 = '0;
  logic          cfg_delay_one = 1'b0;
  logic          cfg_fs_invert = 1'b0;
  logic          s_valid = 1'b0;
  logic [WW-1:0] s_data = '0;
  logic          s_ready, tx_sd, tx_oe, underrun;

  serial_audio_tx i_serial_audio_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync),
    .cfg_dual_phase(cfg_dual_phase), .cfg_ph1_words_m1(cfg_ph1_words_m1),
    .cfg_ph2_words_m1(cfg_ph2_words_m1), .cfg_delay_one(cfg_delay_one),
    .cfg_fs_invert(cfg_fs_invert), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .tx_sd(tx_sd), .tx_oe(tx_oe), .underrun(underrun)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  bit            fs_at  [0:NT-1];
  bit            got_oe [0:NT-1];
  bit            got_sd [0:NT-1];
  logic [WW-1:0] words  [0:NSLT-1];
  bit            wvalid [0:NSLT-1];
  int            slot;
  int            ready_cnt;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < NT; i++) fs_at[i] = 1'b0;
    for (int i = 0; i < NSLT; i++) begin
      words[i]  = WW'(16'h1000 + i * 16'h0111);
      wvalid[i] = 1'b1;
    end
  endtask

  // Drive one strobe per two clock cycles; capture the line after each strobe.
  task automatic play(input int n);
    slot = 0;
    ready_cnt = 0;
    for (int t = 0; t < n; t++) begin
      bit took;
      @(negedge clk);
      bit_tick = 1'b1;
      fsync    = fs_at[t] ^ cfg_fs_invert;
      s_valid  = wvalid[slot];
      s_data   = words[slot];
      #1;
      took = s_ready;
      @(posedge clk);
      if (took) begin
        ready_cnt++;
        if (slot < NSLT - 1) slot++;
      end
      @(negedge clk);
      got_oe[t] = tx_oe;
      got_sd[t] = tx_sd;
      bit_tick  = 1'b0;
      s_valid   = 1'b0;
    end
  endtask

  // Expected: bit k of the data stream sits at strobe index first+k, MSB first.
  task automatic check_stream(input string req, input int first, input int nwords, input int n);
    int bad = -1;
    bit e_oe, e_sd;
    for (int t = 0; t < n; t++) begin
      int k = t - first;
      e_oe = (k >= 0) && (k < nwords * WW);
      e_sd = 1'b0;
      if (e_oe) begin
        logic [WW-1:0] w = wvalid[k / WW] ? words[k / WW] : '0;
        e_sd = w[WW - 1 - (k % WW)];
      end
      if (bad < 0 && (got_oe[t] != e_oe || got_sd[t] != e_sd)) begin
        bad = t;
        $display("  strobe %0d: oe=%0d sd=%0d, expected oe=%0d sd=%0d",
                 t, got_oe[t], got_sd[t], e_oe, e_sd);
      end
    end
    check(req, bad < 0, bad, -1);
  endtask

  task automatic t_reset();
    check("R1 oe", tx_oe == 1'b0, tx_oe, 0);
    check("R1 sd", tx_sd == 1'b0, tx_sd, 0);
    check("R1 ready", s_ready == 1'b0, s_ready, 0);
    check("R1 underrun", underrun == 1'b0, underrun, 0);
  endtask

  task automatic t_single();
    clear_stim();
    cfg_dual_phase = 0; cfg_ph1_words_m1 = 4'd1; cfg_delay_one = 0; cfg_fs_invert = 0;
    words[0] = 16'hA5F0; words[1] = 16'h1234;
    fs_at[2] = 1; fs_at[3] = 1; fs_at[4] = 1;
    play(40);
    check_stream("R2 R5 R7 single phase MSB first", 2, 2, 40);
    check("R8 one ready per word", ready_cnt == 2, ready_cnt, 2);
    check("R9 no underrun when fed", underrun == 1'b0, underrun, 0);
  endtask

  task automatic t_dual_delay();
    clear_stim();
    cfg_dual_phase = 1; cfg_ph1_words_m1 = 0; cfg_ph2_words_m1 = 0; cfg_delay_one = 1;
    words[0] = 16'h8001; words[1] = 16'h7FFE;
    fs_at[2] = 1;
    play(40);
    check("R4 delay bit idle", got_oe[2] == 1'b0, got_oe[2], 0);
    check("R4 first bit one strobe late", got_oe[3] == 1'b1, got_oe[3], 1);
    check_stream("R6 dual phase one word each", 3, 2, 40);
  endtask

  task automatic t_dual_uneven();
    clear_stim();
    cfg_dual_phase = 1; cfg_ph1_words_m1 = 4'd2; cfg_ph2_words_m1 = 4'd1; cfg_delay_one = 0;
    fs_at[1] = 1;
    play(90);
    check_stream("R6 dual phase 3+2 words", 1, 5, 90);
    check("R8 ready count 3+2", ready_cnt == 5, ready_cnt, 5);
  endtask

  task automatic t_polarity();
    clear_stim();
    cfg_dual_phase = 0; cfg_ph1_words_m1 = 0; cfg_delay_one = 0; cfg_fs_invert = 1;
    words[0] = 16'hC3A5;
    fs_at[3] = 1;
    play(26);
    check_stream("R3 inverted frame sync", 3, 1, 26);
    cfg_fs_invert = 0;
  endtask

  task automatic t_mid_sync();
    clear_stim();
    cfg_dual_phase = 0; cfg_ph1_words_m1 = 4'd1; cfg_delay_one = 0;
    fs_at[1] = 1; fs_at[12] = 1; fs_at[30] = 1;
    play(40);
    check_stream("R10 sync inside frame ignored", 1, 2, 40);
  endtask

  task automatic t_max_words();
    clear_stim();
    cfg_dual_phase = 0; cfg_ph1_words_m1 = 4'd15; cfg_delay_one = 0;
    fs_at[2] = 1;
    play(262);
    check_stream("R5 sixteen words", 2, 16, 262);
    check("R8 sixteen readies", ready_cnt == 16, ready_cnt, 16);
  endtask

  task automatic t_back_to_back();
    clear_stim();
    cfg_dual_phase = 0; cfg_ph1_words_m1 = 0; cfg_delay_one = 0;
    words[0] = 16'hF00F; words[1] = 16'h0FF0;
    fs_at[1] = 1; fs_at[17] = 1;
    play(38);
    check_stream("R11 frames without gap", 1, 2, 38);
  endtask

  task automatic t_underrun();
    clear_stim();
    cfg_dual_phase = 0; cfg_ph1_words_m1 = 4'd2; cfg_delay_one = 0;
    words[0] = 16'hFFFF; words[1] = 16'hFFFF; words[2] = 16'h9999;
    wvalid[1] = 1'b0;
    fs_at[1] = 1;
    play(54);
    check_stream("R9 starved slot sends zeros", 1, 3, 54);
    check("R9 underrun set", underrun == 1'b1, underrun, 1);
    repeat (4) @(negedge clk);
    check("R9 underrun sticky", underrun == 1'b1, underrun, 1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_dual_delay();
    t_dual_uneven();
    t_polarity();
    t_mid_sync();
    t_max_words();
    t_back_to_back();
    t_underrun();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule